// File: doc/BRIEF.md
# Bridge Fault Supervisor

This block supervises one power bridge. It takes a digitized overcurrent comparator result and an unsigned die-temperature code, and from them drives an active-low fault flag and a bridge-disable signal for the gate controller. The flag models an open-drain pull-down: a 0 on `fault_n` means the line is pulled low, and a 1 means it is released to an external pull-up.

An overcurrent must persist for a programmable number of cycles before the flag asserts. It must also be absent for a programmable number of cycles before the flag releases. Once the flag releases, a self-timed off interval keeps the bridge disabled before normal drive resumes. A fresh overcurrent during that interval starts it again.

Thermal shutdown trips at a threshold and releases only once the temperature falls below a lower threshold, with no timed retry. A fault input from a second bridge that shares this bridge's enable also switches this bridge off.

Top module: `fault_supervisor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `fault_n` is 1 and `bridge_off` is 0, even if `temp_code` is at or above the trip level during reset (the thermal state is cleared).
- R2: `fault_n` goes to 0 exactly ASSERT_DLY (default 8) rising edges after `oc_raw` is first sampled high, provided `oc_raw` stays high. A high pulse lasting ASSERT_DLY-1 edges leaves `fault_n` at 1 and `bridge_off` at 0.
- R3: Once asserted by overcurrent, `fault_n` returns to 1 exactly RELEASE_DLY (default 4) edges after `oc_raw` is first sampled low. A low gap of RELEASE_DLY-1 edges leaves `fault_n` at 0.
- R4: `bridge_off` is 1 while the overcurrent flag is asserted. It stays 1 for exactly OFF_CYC (default 64) edges after the flag releases, and then returns to 0.
- R5: An overcurrent that asserts the flag during the off interval holds the bridge off. The off interval then restarts in full from the second release.
- R6: When `temp_code` (unsigned whole degrees) is sampled at or above TRIP_C (default 165), `fault_n` becomes 0 and `bridge_off` becomes 1 after that edge. A reading of TRIP_C-1 causes neither.
- R7: A thermal fault persists while `temp_code` is at or above TRIP_C-HYST_C (default 150). It clears on the first edge that samples a lower value.
- R8: While the thermal fault is active, `bridge_off` stays 1 for any length of time, with no timed retry.
- R9: `peer_fault_n` low drives `bridge_off` to 1 in the same cycle without affecting `fault_n`. This is the tied-enable case, where a fault on the other bridge turns this one off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_raw | input | 1 | Digitized overcurrent comparator output, 1 = over threshold |
| temp_code | input | TEMP_W | Die temperature, unsigned whole degrees |
| peer_fault_n | input | 1 | Fault line of a bridge sharing the enable, active low |
| fault_n | output | 1 | Fault flag, 0 = pulled low (fault), 1 = released |
| bridge_off | output | 1 | 1 = gate controller must switch the bridge off |

## Verification
The assertions assume that `oc_raw` and `temp_code` are already synchronous to `clk` and stable around each rising edge. They also assume that `peer_fault_n` is a settled level and not a glitch within a cycle. The stimulus honours this by changing every input one nanosecond after a rising edge and holding it for at least a full cycle. Temperature moves in single steps across the trip and release thresholds, so the hysteresis checks see the exact boundary codes.

// File: rtl/fs_pkg.sv
package fs_pkg;
  // Thermal comparison helpers, kept here so the rules live in one place.
  function automatic logic temp_at_or_above(input int unsigned t, input int unsigned lim);
    return t >= lim;
  endfunction

  function automatic logic temp_below(input int unsigned t, input int unsigned lim);
    return t < lim;
  endfunction

  // Width needed to hold values 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/fs_oc_qualify.sv
module fs_oc_qualify #(
  parameter int unsigned ASSERT_DLY  = 8,
  parameter int unsigned RELEASE_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_raw,
  output logic oc_q
);
  localparam int unsigned MAXD = (ASSERT_DLY > RELEASE_DLY) ? ASSERT_DLY : RELEASE_DLY;
  localparam int unsigned CW   = fs_pkg::cnt_width(MAXD);

  logic [CW-1:0] run_cnt;
  logic [CW-1:0] lim_m1;

  always_comb begin
    lim_m1 = oc_q ? CW'(RELEASE_DLY - 1) : CW'(ASSERT_DLY - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q    <= 1'b0;
      run_cnt <= '0;
    end else if (oc_raw != oc_q) begin
      if (run_cnt == lim_m1) begin
        oc_q    <= oc_raw;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end else begin
      run_cnt <= '0;
    end
  end
endmodule

// File: rtl/fs_thermal.sv
module fs_thermal #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned TRIP_C = 165,
  parameter int unsigned HYST_C = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              therm_hot
);
  localparam int unsigned REL_C = TRIP_C - HYST_C;

  logic trip_now;
  logic cool_now;

  always_comb begin
    trip_now = fs_pkg::temp_at_or_above(int'(temp_code), TRIP_C);
    cool_now = fs_pkg::temp_below(int'(temp_code), REL_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   therm_hot <= 1'b0;
    else if (!therm_hot && trip_now) therm_hot <= 1'b1;
    else if (therm_hot && cool_now)  therm_hot <= 1'b0;
  end
endmodule

// File: rtl/fs_off_timer.sv
module fs_off_timer #(
  parameter int unsigned OFF_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_q,
  output logic off_active
);
  localparam int unsigned CW = fs_pkg::cnt_width(OFF_CYC);

  logic [CW-1:0] off_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              off_cnt <= '0;
    else if (oc_q)           off_cnt <= CW'(OFF_CYC);
    else if (off_cnt != '0)  off_cnt <= off_cnt - 1'b1;
  end

  assign off_active = (off_cnt != '0);
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int unsigned TEMP_W      = 8,
  parameter int unsigned TRIP_C      = 165,
  parameter int unsigned HYST_C      = 15,
  parameter int unsigned ASSERT_DLY  = 8,
  parameter int unsigned RELEASE_DLY = 4,
  parameter int unsigned OFF_CYC     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oc_raw,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              peer_fault_n,
  output logic              fault_n,
  output logic              bridge_off
);
  // Internal events, named so the checker can observe them.
  logic oc_q;
  logic therm_hot;
  logic off_active;

  fs_oc_qualify #(.ASSERT_DLY(ASSERT_DLY), .RELEASE_DLY(RELEASE_DLY)) u_ocq (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .oc_q(oc_q));

  fs_thermal #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .HYST_C(HYST_C)) u_therm (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .therm_hot(therm_hot));

  fs_off_timer #(.OFF_CYC(OFF_CYC)) u_off (
    .clk(clk), .rst_n(rst_n), .oc_q(oc_q), .off_active(off_active));

  assign fault_n    = ~(oc_q | therm_hot);
  assign bridge_off = oc_q | off_active | therm_hot | ~peer_fault_n;
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned TRIP_C = 165,
  parameter int unsigned HYST_C = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oc_raw,
  input logic [TEMP_W-1:0] temp_code,
  input logic              peer_fault_n,
  input logic              fault_n,
  input logic              bridge_off,
  input logic              oc_q,
  input logic              therm_hot,
  input logic              off_active
);
  localparam int unsigned REL_C = TRIP_C - HYST_C;

  p_oc_rise_needs_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_q) |-> $past(oc_raw));
  p_oc_fall_needs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_q) |-> !$past(oc_raw));
  p_off_loaded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oc_q |=> off_active);
  p_off_ends_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(off_active) |-> !$past(oc_q));
  p_trip_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(therm_hot) |-> (int'($past(temp_code)) >= TRIP_C));
  p_release_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(therm_hot) |-> (int'($past(temp_code)) < REL_C));
  p_hot_holds_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    therm_hot |-> (bridge_off && !fault_n));
  p_peer_forces_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !peer_fault_n |-> bridge_off);
endmodule

bind fault_supervisor fault_supervisor_chk #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .HYST_C(HYST_C)) u_chk (
  .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .temp_code(temp_code),
  .peer_fault_n(peer_fault_n), .fault_n(fault_n), .bridge_off(bridge_off),
  .oc_q(oc_q), .therm_hot(therm_hot), .off_active(off_active));

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int A   = 8;
  localparam int RL  = 4;
  localparam int OFF = 64;
  localparam int TRIP = 165;
  localparam int REL  = 150;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oc_raw = 1'b0;
  logic [7:0] temp_code = 8'd25;
  logic       peer_fault_n = 1'b1;
  logic       fault_n;
  logic       bridge_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fault_supervisor i_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .temp_code(temp_code),
    .peer_fault_n(peer_fault_n), .fault_n(fault_n), .bridge_off(bridge_off));

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic settle();
    oc_raw = 1'b0; temp_code = 8'd25; peer_fault_n = 1'b1;
    step(A + RL + OFF + 8);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; temp_code = 8'd200; oc_raw = 1'b1;
    step(3);
    chk("R1", "fault_n in reset", fault_n, 1'b1);
    chk("R1", "bridge_off in reset", bridge_off, 1'b0);
    temp_code = 8'd25; oc_raw = 1'b0;
    rst_n = 1'b1;
    step(1);
    chk("R1", "fault_n after reset", fault_n, 1'b1);
    chk("R1", "bridge_off after reset", bridge_off, 1'b0);
  endtask

  task automatic t_oc_timing();
    oc_raw = 1'b1;
    step(A - 1);
    chk("R2", "fault_n one before assert", fault_n, 1'b1);
    step(1);
    chk("R2", "fault_n at assert", fault_n, 1'b0);
    chk("R4", "bridge_off during oc", bridge_off, 1'b1);
    oc_raw = 1'b0;
    step(RL - 1);
    chk("R3", "fault_n one before release", fault_n, 1'b0);
    step(1);
    chk("R3", "fault_n at release", fault_n, 1'b1);
    chk("R4", "bridge_off at release", bridge_off, 1'b1);
    step(OFF - 1);
    chk("R4", "bridge_off end of off time", bridge_off, 1'b1);
    step(1);
    chk("R4", "bridge_off after off time", bridge_off, 1'b0);
  endtask

  task automatic t_oc_glitch();
    oc_raw = 1'b1;
    step(A - 1);
    oc_raw = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk("R2", "fault_n after short pulse", fault_n, 1'b1);
      chk("R2", "bridge_off after short pulse", bridge_off, 1'b0);
    end
    oc_raw = 1'b1;
    step(A);
    chk("R2", "fault_n asserted", fault_n, 1'b0);
    oc_raw = 1'b0;
    step(RL - 1);
    oc_raw = 1'b1;
    step(3);
    chk("R3", "fault_n after short gap", fault_n, 1'b0);
    settle();
  endtask

  task automatic t_restart();
    oc_raw = 1'b1; step(A);
    oc_raw = 1'b0; step(RL);
    chk("R5", "first release", fault_n, 1'b1);
    step(OFF / 2);
    chk("R5", "bridge_off mid off time", bridge_off, 1'b1);
    oc_raw = 1'b1; step(A);
    chk("R5", "second assert", fault_n, 1'b0);
    chk("R5", "bridge_off second oc", bridge_off, 1'b1);
    oc_raw = 1'b0; step(RL);
    chk("R5", "second release", fault_n, 1'b1);
    step(OFF - 1);
    chk("R5", "bridge_off full restarted interval", bridge_off, 1'b1);
    step(1);
    chk("R5", "bridge_off after restarted interval", bridge_off, 1'b0);
  endtask

  task automatic t_thermal();
    temp_code = 8'(TRIP - 1); step(2);
    chk("R6", "fault_n below trip", fault_n, 1'b1);
    chk("R6", "bridge_off below trip", bridge_off, 1'b0);
    temp_code = 8'(TRIP); step(1);
    chk("R6", "fault_n at trip", fault_n, 1'b0);
    chk("R6", "bridge_off at trip", bridge_off, 1'b1);
    temp_code = 8'(REL); step(3);
    chk("R7", "fault_n at release level", fault_n, 1'b0);
    temp_code = 8'(REL - 1); step(1);
    chk("R7", "fault_n below release", fault_n, 1'b1);
    chk("R7", "bridge_off below release", bridge_off, 1'b0);
  endtask

  task automatic t_thermal_hold();
    temp_code = 8'd200; step(1);
    step(OFF * 3);
    chk("R8", "bridge_off long hot", bridge_off, 1'b1);
    chk("R8", "fault_n long hot", fault_n, 1'b0);
    temp_code = 8'd25; step(1);
    chk("R8", "bridge_off after cooling", bridge_off, 1'b0);
  endtask

  task automatic t_peer();
    peer_fault_n = 1'b0; #1;
    chk("R9", "bridge_off peer fault", bridge_off, 1'b1);
    chk("R9", "fault_n peer fault", fault_n, 1'b1);
    step(2);
    chk("R9", "bridge_off peer held", bridge_off, 1'b1);
    peer_fault_n = 1'b1; #1;
    chk("R9", "bridge_off peer clear", bridge_off, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_oc_timing();
    settle();
    t_oc_glitch();
    t_restart();
    settle();
    t_thermal();
    settle();
    t_thermal_hold();
    settle();
    t_peer();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule